// File: doc/BRIEF.md
# Video Sync Pulse Corrector

This block sits between the sync inputs of a display controller and the timing logic behind it, and cleans up the sync pulses. Both sync inputs are expected to be active-high. During vertical retrace, many sources insert equalization pulses at twice the line rate. After every horizontal pulse it lets through, the corrector opens an inhibit window. Any horizontal pulse that starts inside that window is removed whole from the horizontal output, so only the pulses at the true line rate remain.

On the vertical side there are two ways to lengthen the vertical output. In counted extension, the output stays high after the vertical input falls until a programmed number of horizontal lines have started. This happens only when equalization pulses were flagged during that vertical pulse. In continuous mode, the equalization-detect flag is ORed into the vertical output. All correction is forced off while the free-running generator or either acquisition mode is active.

The inhibit timer counts on a slow tick enable, where one tick is a quarter microsecond. Its window is (gate count + 1 − 8) ticks. The 8-tick deduction is one minimum pulse width, so the window ends before the next genuine line pulse.

Top module: `sync_corrector`

## Requirements
- R1: When inhibit is enabled and a horizontal pulse that was passed ends, a window of (hGateCount + 1 − 8) ticks opens. A horizontal pulse whose synchronized rising edge falls inside the window is removed whole from hSyncOut.
- R2: A horizontal pulse is passed to hSyncOut unchanged, 3 clocks later, when inhibit is disabled or the pulse starts after the window has closed.
- R3: If hGateCount + 1 − 8 is zero or less, no window opens and every horizontal pulse passes.
- R4: The inhibit timer advances only on clocks where tickEn is high, so the window length in clocks scales with the tick spacing.
- R5: vSyncOut follows vSyncIn with 3 clocks of latency, and it is never low while the delayed vertical input is high.
- R6: When vertical correction is on and eqDetectIn was seen during the vertical pulse, vSyncOut stays high after the vertical input falls. It drops in the same clock that hSyncOut rises for the vExtLines-th horizontal pulse after the fall.
- R7: If eqDetectIn was not seen during the vertical pulse, there is no counted extension.
- R8: A vExtLines value of zero, or vCorrDisable high, turns off counted extension and continuous mode. This holds even with eqFollowEn set.
- R9: With vertical correction on, and both vContinuousEn and eqFollowEn high, vSyncOut is the OR of the vertical input and eqDetectIn, each delayed 3 clocks.
- R10: While freeRunOn, hAcqOn or vAcqOn is high, horizontal pulses all pass and vSyncOut follows only vSyncIn.
- R11: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Quarter-microsecond tick enable for the inhibit timer |
| hSyncIn | input | 1 | Horizontal sync, active high, asynchronous |
| vSyncIn | input | 1 | Vertical sync, active high, asynchronous |
| eqDetectIn | input | 1 | Equalization pulses detected flag |
| hInhibitEn | input | 1 | Enable horizontal equalization-pulse removal |
| hGateCount | input | GATE_W | Gate count setting the inhibit window |
| vExtLines | input | LINE_W | Lines of vertical extension; zero disables vertical correction |
| vCorrDisable | input | 1 | Turns off vertical correction |
| eqFollowEn | input | 1 | Allows equalization flag onto vertical output |
| vContinuousEn | input | 1 | Selects continuous (OR) vertical extension |
| freeRunOn | input | 1 | Free-running generator active; blocks correction |
| hAcqOn | input | 1 | Horizontal acquisition active; blocks correction |
| vAcqOn | input | 1 | Vertical acquisition active; blocks correction |
| hSyncOut | output | 1 | Corrected horizontal sync, registered |
| vSyncOut | output | 1 | Corrected vertical sync, registered |

## Verification
The bench builds the block with its default parameters: 8-bit gate and line counts, two synchronizer stages and an 8-tick minimum-pulse deduction. With those settings the full inhibit window fits in a few hundred clocks even when the tick arrives only every third clock. That makes random gate counts, tick spacings and pulse gaps placed a safe margin either side of the window edge cheap to run. The 8-bit line count allows random extensions of one to five lines with random line periods. Directed cases cover gate counts whose window is zero, a zero line count, the disable bit and the blocking modes.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  // Strobes and mode levels the control hands to the datapath each clock
  typedef struct packed {
    logic hLevel;
    logic hRise;
    logic hFall;
    logic vLevel;
    logic vRise;
    logic vFall;
    logic eqLevel;
    logic inhibitOn;
    logic vCorrOn;
    logic contOn;
  } scStrobes_t;
endpackage

// File: rtl/sc_sync.sv
`timescale 1ns/1ps
module sc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              eqDetectIn,
  input  logic              hInhibitEn,
  input  logic [LINE_W-1:0] vExtLines,
  input  logic              vCorrDisable,
  input  logic              eqFollowEn,
  input  logic              vContinuousEn,
  input  logic              freeRunOn,
  input  logic              hAcqOn,
  input  logic              vAcqOn,
  output scStrobes_t        st
);
  logic [2:0] syncQ;
  logic       hPrev, vPrev;
  logic       allowed;

  sc_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({hSyncIn, vSyncIn, eqDetectIn}),
    .q   (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
    end else begin
      hPrev <= syncQ[2];
      vPrev <= syncQ[1];
    end
  end

  assign allowed = !(freeRunOn || hAcqOn || vAcqOn);

  always_comb begin
    st.hLevel    = syncQ[2];
    st.hRise     = syncQ[2] && !hPrev;
    st.hFall     = !syncQ[2] && hPrev;
    st.vLevel    = syncQ[1];
    st.vRise     = syncQ[1] && !vPrev;
    st.vFall     = !syncQ[1] && vPrev;
    st.eqLevel   = syncQ[0];
    st.inhibitOn = hInhibitEn && allowed;
    st.vCorrOn   = allowed && !vCorrDisable && (vExtLines != '0);
    st.contOn    = st.vCorrOn && eqFollowEn && vContinuousEn;
  end

  // R5: a vertical edge strobe lasts a single clock
  a_r5_vfall_single: assert property (@(posedge clk) disable iff (!rstN)
    st.vFall |=> !st.vFall);
endmodule

// File: rtl/sc_datapath.sv
`timescale 1ns/1ps
module sc_datapath
  import sc_pkg::*;
#(
  parameter int GATE_W          = 8,
  parameter int LINE_W          = 8,
  parameter int MIN_PULSE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  scStrobes_t        st,
  input  logic [GATE_W-1:0] hGateCount,
  input  logic [LINE_W-1:0] vExtLines,
  output logic              hSyncOut,
  output logic              vSyncOut
);
  localparam int TIMER_W = GATE_W + 1;
  localparam logic [TIMER_W-1:0] MIN_TICKS = TIMER_W'(MIN_PULSE_TICKS);

  // ---------------- horizontal inhibit ----------------
  logic [TIMER_W-1:0] timer, gatePlus, loadVal;
  logic               inhibitActive, hMask, suppress;

  assign gatePlus      = TIMER_W'(hGateCount) + TIMER_W'(1);
  assign loadVal       = (gatePlus > MIN_TICKS) ? gatePlus - MIN_TICKS : '0;
  assign inhibitActive = (timer != '0);
  assign suppress      = st.inhibitOn && (st.hRise ? inhibitActive : hMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    timer <= '0;
    else if (!st.inhibitOn)       timer <= '0;
    else if (st.hFall && !hMask)  timer <= loadVal;
    else if (tickEn && inhibitActive) timer <= timer - TIMER_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hMask    <= 1'b0;
      hSyncOut <= 1'b0;
    end else begin
      hMask    <= st.hLevel && suppress;
      hSyncOut <= st.hLevel && !suppress;
    end
  end

  // ---------------- vertical extension ----------------
  logic [LINE_W-1:0] lineCnt, cntNext;
  logic [LINE_W:0]   lineInc;
  logic              extActive, extNext, eqSeen;

  assign lineInc = {1'b0, lineCnt} + (LINE_W+1)'(1);

  always_comb begin
    extNext = extActive;
    cntNext = lineCnt;
    if (!st.vCorrOn || st.vRise) begin
      extNext = 1'b0;
      cntNext = '0;
    end else if (st.vFall) begin
      extNext = eqSeen || st.eqLevel;
      cntNext = '0;
    end else if (extActive && st.hRise) begin
      cntNext = lineInc[LINE_W-1:0];
      extNext = (lineInc < {1'b0, vExtLines});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extActive <= 1'b0;
      lineCnt   <= '0;
      eqSeen    <= 1'b0;
      vSyncOut  <= 1'b0;
    end else begin
      extActive <= extNext;
      lineCnt   <= cntNext;
      eqSeen    <= st.vRise ? st.eqLevel : (eqSeen || st.eqLevel);
      vSyncOut  <= st.vLevel || extNext || (st.contOn && st.eqLevel);
    end
  end

  // ---------------- assertions ----------------
  a_r1_window_opens: assert property (@(posedge clk) disable iff (!rstN)
    st.inhibitOn && st.hFall && !hMask && (loadVal != '0) |=> inhibitActive);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    st.inhibitOn && !st.hFall && !tickEn |=> $stable(timer));

  a_r2_pass_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !st.inhibitOn && st.hLevel |=> hSyncOut);

  a_r5_v_follows: assert property (@(posedge clk) disable iff (!rstN)
    st.vLevel |=> vSyncOut);

  a_r6_ext_holds: assert property (@(posedge clk) disable iff (!rstN)
    extActive && st.vCorrOn && !st.vRise && !st.vFall && !st.hRise |=> vSyncOut);

  a_r8_no_corr: assert property (@(posedge clk) disable iff (!rstN)
    !st.vCorrOn && !st.vLevel |=> !vSyncOut);
endmodule

// File: rtl/sync_corrector.sv
`timescale 1ns/1ps
module sync_corrector
  import sc_pkg::*;
#(
  parameter int GATE_W          = 8,
  parameter int LINE_W          = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int MIN_PULSE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              eqDetectIn,
  input  logic              hInhibitEn,
  input  logic [GATE_W-1:0] hGateCount,
  input  logic [LINE_W-1:0] vExtLines,
  input  logic              vCorrDisable,
  input  logic              eqFollowEn,
  input  logic              vContinuousEn,
  input  logic              freeRunOn,
  input  logic              hAcqOn,
  input  logic              vAcqOn,
  output logic              hSyncOut,
  output logic              vSyncOut
);
  scStrobes_t st;

  sc_ctrl #(.SYNC_STAGES(SYNC_STAGES), .LINE_W(LINE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hSyncIn      (hSyncIn),
    .vSyncIn      (vSyncIn),
    .eqDetectIn   (eqDetectIn),
    .hInhibitEn   (hInhibitEn),
    .vExtLines    (vExtLines),
    .vCorrDisable (vCorrDisable),
    .eqFollowEn   (eqFollowEn),
    .vContinuousEn(vContinuousEn),
    .freeRunOn    (freeRunOn),
    .hAcqOn       (hAcqOn),
    .vAcqOn       (vAcqOn),
    .st           (st)
  );

  sc_datapath #(
    .GATE_W(GATE_W), .LINE_W(LINE_W), .MIN_PULSE_TICKS(MIN_PULSE_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .st        (st),
    .hGateCount(hGateCount),
    .vExtLines (vExtLines),
    .hSyncOut  (hSyncOut),
    .vSyncOut  (vSyncOut)
  );
endmodule

// File: tb/sync_corrector_tb.sv
`timescale 1ns/1ps
module sync_corrector_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       hSyncIn = 1'b0, vSyncIn = 1'b0, eqDetectIn = 1'b0;
  logic       hInhibitEn = 1'b0;
  logic [7:0] hGateCount = 8'd0, vExtLines = 8'd0;
  logic       vCorrDisable = 1'b0, eqFollowEn = 1'b0, vContinuousEn = 1'b0;
  logic       freeRunOn = 1'b0, hAcqOn = 1'b0, vAcqOn = 1'b0;
  logic       hSyncOut, vSyncOut;

  int testsRun = 0, testsFailed = 0;
  int tickDiv = 1, tickPhase = 0;
  int hRises = 0, vRunCur = 0, vRunLast = 0;
  logic hPrevMon = 1'b0;

  sync_corrector u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .eqDetectIn(eqDetectIn), .hInhibitEn(hInhibitEn), .hGateCount(hGateCount),
    .vExtLines(vExtLines), .vCorrDisable(vCorrDisable), .eqFollowEn(eqFollowEn),
    .vContinuousEn(vContinuousEn), .freeRunOn(freeRunOn), .hAcqOn(hAcqOn),
    .vAcqOn(vAcqOn), .hSyncOut(hSyncOut), .vSyncOut(vSyncOut)
  );

  always #10 clk = ~clk;

  // tick generator: one tick every tickDiv clocks
  always @(posedge clk) begin
    #1;
    if (tickPhase + 1 >= tickDiv) begin tickPhase = 0; tickEn = 1'b1; end
    else begin tickPhase++; tickEn = 1'b0; end
  end

  // output monitors, sampled on the falling edge
  always @(negedge clk) begin
    if (hSyncOut && !hPrevMon) hRises++;
    hPrevMon = hSyncOut;
    if (vSyncOut) vRunCur++;
    else if (vRunCur != 0) begin vRunLast = vRunCur; vRunCur = 0; end
  end

  task automatic check(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic defaults();
    hInhibitEn = 0; hGateCount = 0; vExtLines = 0; vCorrDisable = 0;
    eqFollowEn = 0; vContinuousEn = 0; freeRunOn = 0; hAcqOn = 0; vAcqOn = 0;
    eqDetectIn = 0; tickDiv = 1;
  endtask

  // expected number of output pulses for a pulse pair with gap d
  function automatic int expHPulses(int g, int d, int k, bit inhOn);
    int win;
    win = g + 1 - 8;
    if (!inhOn || win <= 0) return 2;
    return (d <= win * k) ? 1 : 2;
  endfunction

  function automatic int expVRun(int w, int g0, int p, int n, bit eq, bit corrOn);
    if (corrOn && eq && n > 0) return w + g0 + (n - 1) * p;
    return w;
  endfunction

  // two horizontal pulses separated by d low clocks; returns output pulse count
  task automatic hPair(int d, output int cnt);
    int start;
    cyc(10);
    start = hRises;
    hSyncIn = 1; cyc(4); hSyncIn = 0;
    cyc(d);
    hSyncIn = 1; cyc(4); hSyncIn = 0;
    cyc(800);
    cnt = hRises - start;
  endtask

  task automatic vBurst(int w, int g0, int p, int n, bit eq, output int run);
    vRunLast = 0;
    eqDetectIn = eq; cyc(6);
    vSyncIn = 1; cyc(w); vSyncIn = 0;
    cyc(g0);
    for (int i = 0; i < n + 2; i++) begin
      hSyncIn = 1; cyc(4); hSyncIn = 0; cyc(p - 4);
    end
    eqDetectIn = 0;
    cyc(30);
    run = vRunLast;
  endtask

  initial begin
    #3_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int cnt, run, n;
    void'($urandom(32'd2024));
    defaults();
    cyc(5);
    check("R11 hSyncOut in reset", int'(hSyncOut), 0);
    check("R11 vSyncOut in reset", int'(vSyncOut), 0);
    rstN = 1; cyc(5);
    check("R11 hSyncOut after reset", int'(hSyncOut), 0);
    check("R11 vSyncOut after reset", int'(vSyncOut), 0);

    // R2 / R5 latency
    @(negedge clk); hSyncIn = 1; vSyncIn = 1; n = 0;
    while (n < 10) begin @(negedge clk); n++; if (hSyncOut) break; end
    check("R2 horizontal latency", n, 3);
    check("R5 vertical same latency", int'(vSyncOut), 1);
    hSyncIn = 0; vSyncIn = 0; cyc(10);

    // directed inhibit cases
    hInhibitEn = 1; hGateCount = 40;
    hPair(10, cnt); check("R1 pulse inside window removed", cnt, expHPulses(40, 10, 1, 1));
    hPair(45, cnt); check("R2 pulse after window passes", cnt, expHPulses(40, 45, 1, 1));
    hGateCount = 7;
    hPair(1, cnt);  check("R3 zero window passes", cnt, expHPulses(7, 1, 1, 1));
    hGateCount = 0;
    hPair(1, cnt);  check("R3 wrapped window passes", cnt, expHPulses(0, 1, 1, 1));
    hGateCount = 60; hInhibitEn = 0;
    hPair(10, cnt); check("R2 inhibit disabled passes", cnt, expHPulses(60, 10, 1, 0));
    hInhibitEn = 1; freeRunOn = 1;
    hPair(10, cnt); check("R10 free-run blocks inhibit", cnt, 2);
    freeRunOn = 0; hAcqOn = 1;
    hPair(10, cnt); check("R10 acquisition blocks inhibit", cnt, 2);
    hAcqOn = 0;
    tickDiv = 4; hGateCount = 30;
    hPair(70, cnt); check("R4 slow tick stretches window", cnt, expHPulses(30, 70, 4, 1));
    hPair(110, cnt); check("R4 slow tick window ends", cnt, expHPulses(30, 110, 4, 1));
    tickDiv = 1;

    // random inhibit cases
    for (int i = 0; i < 24; i++) begin
      int g, k, d, win;
      g = 10 + int'($urandom % 70);
      k = 1 + int'($urandom % 3);
      win = (g - 7) * k;
      if ($urandom % 2 == 1) begin d = win - 2 * k - 2; if (d < 1) d = 1; end
      else d = win + 2 * k + 2;
      hGateCount = 8'(g); tickDiv = k;
      hPair(d, cnt);
      check("R1 random window", cnt, expHPulses(g, d, k, 1));
    end
    defaults(); cyc(20);

    // directed vertical cases
    vExtLines = 3;
    vBurst(7, 6, 20, 3, 1, run); check("R6 counted extension", run, expVRun(7, 6, 20, 3, 1, 1));
    vBurst(7, 6, 20, 3, 0, run); check("R7 no eq no extension", run, expVRun(7, 6, 20, 3, 0, 1));
    vExtLines = 0;
    vBurst(9, 6, 20, 3, 1, run); check("R8 zero lines no extension", run, expVRun(9, 6, 20, 0, 1, 1));
    vExtLines = 2; vCorrDisable = 1;
    vBurst(9, 6, 20, 2, 1, run); check("R8 disable bit no extension", run, expVRun(9, 6, 20, 2, 1, 0));
    vCorrDisable = 0; vAcqOn = 1;
    vBurst(9, 6, 20, 2, 1, run); check("R10 acquisition blocks extension", run, expVRun(9, 6, 20, 2, 1, 0));
    vAcqOn = 0;

    // continuous mode
    vExtLines = 3; vContinuousEn = 1; eqFollowEn = 1; vRunLast = 0;
    eqDetectIn = 1; cyc(13); eqDetectIn = 0; cyc(10);
    check("R9 continuous follows eq", vRunLast, 13);
    eqFollowEn = 0; vRunLast = 0;
    eqDetectIn = 1; cyc(13); eqDetectIn = 0; cyc(10);
    check("R9 continuous needs eq enable", vRunLast, 0);
    eqFollowEn = 1; vCorrDisable = 1; vRunLast = 0;
    eqDetectIn = 1; cyc(13); eqDetectIn = 0; cyc(10);
    check("R8 disable blocks continuous", vRunLast, 0);
    defaults(); cyc(10);

    // random vertical cases
    for (int i = 0; i < 12; i++) begin
      int nl, w, g0, p;
      bit eq;
      nl = 1 + int'($urandom % 5);
      w = 3 + int'($urandom % 20);
      g0 = 5 + int'($urandom % 20);
      p = 10 + int'($urandom % 30);
      eq = 1'($urandom % 2);
      vExtLines = 8'(nl);
      vBurst(w, g0, p, nl, eq, run);
      check("R6 random extension", run, expVRun(w, g0, p, nl, eq, 1));
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule